// File: doc/BRIEF.md
# PLL Control and Status Register Bank

This block is the register front end for an on-chip phase-locked loop. Software reaches it over a plain 32-bit bus: an address, a write strobe and write data, with read data returned combinationally for the current address. The bank keeps the standby controls and the divider, multiplier, fraction and spread settings. Every stored field is driven straight out to the PLL. A monitor word reports the lock signal that comes back from the PLL.

In the standby register and in the first setting register, each control field has a write-enable bit in the upper halfword of the same data word. A write changes a field only when its enable bit is set in that write. Software can therefore change one field without reading the register first. The fraction, integer and spread registers have no such enables and take every write. The enable bits are not stored. After reset every field is zero, which keeps the PLL in standby.

Top module: `pll_ctrl_regs`

## Requirements
- R1: After reset every output field is 0, and a read of any address returns 0 except for the lock bit of the monitor word.
- R2: Standby word (0x140): bit 0 (PLL run, active-high release from standby) takes wdata[0] only in a write with wdata[16] = 1. Otherwise it keeps its value.
- R3: Standby word: bit 2 (spread enable) is loaded only when wdata[18] = 1, and bit 4 (down-spread) only when wdata[20] = 1. Each enable acts independently of the others.
- R4: Setting word 1 (0x144): post-divider 1 in bits 3:0 is gated by wdata[16], post-divider 2 in bits 7:4 by wdata[20], and the reference divider in bits 13:8 by wdata[24].
- R5: Setting word 3 (0x14C): the 24-bit fraction in bits 31:8 is loaded on every write. Bits 7:0 read as 0.
- R6: Setting word 4 (0x150): the 12-bit integer multiplier in bits 27:16 is loaded on every write. Setting word 5 (0x154): the 8-bit spread value in bits 7:0 is loaded on every write.
- R7: Monitor word (0x15C): bit 4 reflects lock_in and all other bits read as 0. Writes to it have no effect.
- R8: Write-enable bits are never stored and always read back as 0. Stored fields read back at the bit positions they were written to.
- R9: Reads from any other address return 0, and writes to them change no field.
- R10: A cycle with wr_en low changes no field, whatever addr and wdata carry.
- R11: A read in the same cycle as a write to that word returns the value from before the write. The new value appears after the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 12 | Byte address of the word |
| wr_en | input | 1 | Write strobe for this cycle |
| wdata | input | 32 | Write data, with field enables in the upper halfword |
| rdata | output | 32 | Read data for addr |
| lock_in | input | 1 | Lock indication from the PLL |
| pll_run | output | 1 | Releases the PLL from standby |
| ssc_en | output | 1 | Spread-spectrum enable |
| down_spread | output | 1 | Down-spread select |
| post_div1 | output | 4 | Post-divider 1 setting |
| post_div2 | output | 4 | Post-divider 2 setting |
| ref_div | output | 6 | Reference divider setting |
| frac | output | 24 | Fractional multiplier |
| int_mult | output | 12 | Integer multiplier |
| spread_val | output | 8 | Spread modulation value |

## Verification
A write and a read can fall in the same cycle, because the read port is combinational on the same address that the write uses. On every random write, the bench samples rdata while the strobe is still high and before the clock edge. That sample must match the model's value from before the write. The bench then samples again after the edge and expects the updated value. Random data also sets and clears the write-enable bits in arbitrary mixes, so a field that changes without its enable, or fails to change with it, shows up in the per-field comparison.

// File: rtl/pll_ctrl_regs.sv
module pll_ctrl_regs #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] A_STBY = 12'h140,
  parameter logic [ADDR_W-1:0] A_SET1 = 12'h144,
  parameter logic [ADDR_W-1:0] A_SET3 = 12'h14C,
  parameter logic [ADDR_W-1:0] A_SET4 = 12'h150,
  parameter logic [ADDR_W-1:0] A_SET5 = 12'h154,
  parameter logic [ADDR_W-1:0] A_MON  = 12'h15C,
  parameter int PD_W   = 4,
  parameter int REF_W  = 6,
  parameter int FRAC_W = 24,
  parameter int INT_W  = 12,
  parameter int SPR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              lock_in,
  output logic              pll_run,
  output logic              ssc_en,
  output logic              down_spread,
  output logic [PD_W-1:0]   post_div1,
  output logic [PD_W-1:0]   post_div2,
  output logic [REF_W-1:0]  ref_div,
  output logic [FRAC_W-1:0] frac,
  output logic [INT_W-1:0]  int_mult,
  output logic [SPR_W-1:0]  spread_val
);
  localparam int PD2_LSB  = 4;
  localparam int REF_LSB  = 8;
  localparam int FRAC_LSB = 8;
  localparam int INT_LSB  = 16;

  wire wr_stby = wr_en && (addr == A_STBY);
  wire wr_set1 = wr_en && (addr == A_SET1);
  wire wr_set3 = wr_en && (addr == A_SET3);
  wire wr_set4 = wr_en && (addr == A_SET4);
  wire wr_set5 = wr_en && (addr == A_SET5);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pll_run     <= 1'b0;
      ssc_en      <= 1'b0;
      down_spread <= 1'b0;
      post_div1   <= '0;
      post_div2   <= '0;
      ref_div     <= '0;
      frac        <= '0;
      int_mult    <= '0;
      spread_val  <= '0;
    end else begin
      if (wr_stby && wdata[16]) pll_run     <= wdata[0];
      if (wr_stby && wdata[18]) ssc_en      <= wdata[2];
      if (wr_stby && wdata[20]) down_spread <= wdata[4];
      if (wr_set1 && wdata[16]) post_div1   <= wdata[PD_W-1:0];
      if (wr_set1 && wdata[20]) post_div2   <= wdata[PD2_LSB +: PD_W];
      if (wr_set1 && wdata[24]) ref_div     <= wdata[REF_LSB +: REF_W];
      if (wr_set3)              frac        <= wdata[FRAC_LSB +: FRAC_W];
      if (wr_set4)              int_mult    <= wdata[INT_LSB +: INT_W];
      if (wr_set5)              spread_val  <= wdata[SPR_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_STBY: begin
        rdata[0] = pll_run;
        rdata[2] = ssc_en;
        rdata[4] = down_spread;
      end
      A_SET1: begin
        rdata[PD_W-1:0]           = post_div1;
        rdata[PD2_LSB +: PD_W]    = post_div2;
        rdata[REF_LSB +: REF_W]   = ref_div;
      end
      A_SET3:  rdata[FRAC_LSB +: FRAC_W] = frac;
      A_SET4:  rdata[INT_LSB +: INT_W]   = int_mult;
      A_SET5:  rdata[SPR_W-1:0]          = spread_val;
      A_MON:   rdata[4]                  = lock_in;
      default: rdata = '0;
    endcase
  end
endmodule

module pll_ctrl_regs_chk #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] A_STBY = 12'h140,
  parameter logic [ADDR_W-1:0] A_SET1 = 12'h144,
  parameter logic [ADDR_W-1:0] A_SET3 = 12'h14C,
  parameter logic [ADDR_W-1:0] A_MON  = 12'h15C,
  parameter int REF_W  = 6,
  parameter int FRAC_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [31:0]       wdata,
  input logic [31:0]       rdata,
  input logic              lock_in,
  input logic              pll_run,
  input logic [REF_W-1:0]  ref_div,
  input logic [FRAC_W-1:0] frac
);
  assert_run_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_STBY && !wdata[16]) |=> $stable(pll_run));

  assert_ref_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_SET1 && !wdata[24]) |=> $stable(ref_div));

  assert_frac_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_SET3) |=> (frac == $past(wdata[31:8])));

  assert_mon_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_MON) |-> (rdata == {27'd0, lock_in, 4'd0}));

  assert_idle_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(frac) && $stable(pll_run) && $stable(ref_div)));

  assert_stby_hi_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_STBY) |-> (rdata[31:5] == '0));
endmodule

bind pll_ctrl_regs pll_ctrl_regs_chk #(
  .ADDR_W(ADDR_W), .A_STBY(A_STBY), .A_SET1(A_SET1), .A_SET3(A_SET3),
  .A_MON(A_MON), .REF_W(REF_W), .FRAC_W(FRAC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
  .rdata(rdata), .lock_in(lock_in), .pll_run(pll_run), .ref_div(ref_div),
  .frac(frac)
);

// File: tb/tb_pll_ctrl_regs.sv
`timescale 1ns/100ps
module tb_pll_ctrl_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        lock_in = 1'b0;
  logic        pll_run, ssc_en, down_spread;
  logic [3:0]  post_div1, post_div2;
  logic [5:0]  ref_div;
  logic [23:0] frac;
  logic [11:0] int_mult;
  logic [7:0]  spread_val;

  pll_ctrl_regs dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .lock_in(lock_in), .pll_run(pll_run), .ssc_en(ssc_en),
    .down_spread(down_spread), .post_div1(post_div1), .post_div2(post_div2),
    .ref_div(ref_div), .frac(frac), .int_mult(int_mult), .spread_val(spread_val)
  );

  always #2.5 clk = ~clk;

  int tests = 0, fails = 0;
  bit done = 0;

  logic m_run, m_ssc, m_ds;
  logic [3:0] m_pd1, m_pd2;
  logic [5:0] m_ref;
  logic [23:0] m_frac;
  logic [11:0] m_int;
  logic [7:0] m_spr;

  logic [11:0] addrs [10] = '{12'h140, 12'h144, 12'h14C, 12'h150, 12'h154,
                              12'h15C, 12'h148, 12'h158, 12'h000, 12'h13C};

  function automatic logic [31:0] exp_read(input logic [11:0] a);
    logic [31:0] r = '0;
    case (a)
      12'h140: begin r[0] = m_run; r[2] = m_ssc; r[4] = m_ds; end
      12'h144: begin r[3:0] = m_pd1; r[7:4] = m_pd2; r[13:8] = m_ref; end
      12'h14C: r[31:8] = m_frac;
      12'h150: r[27:16] = m_int;
      12'h154: r[7:0] = m_spr;
      12'h15C: r[4] = lock_in;
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic model_write(input logic [11:0] a, input logic [31:0] d);
    case (a)
      12'h140: begin
        if (d[16]) m_run = d[0];
        if (d[18]) m_ssc = d[2];
        if (d[20]) m_ds  = d[4];
      end
      12'h144: begin
        if (d[16]) m_pd1 = d[3:0];
        if (d[20]) m_pd2 = d[7:4];
        if (d[24]) m_ref = d[13:8];
      end
      12'h14C: m_frac = d[31:8];
      12'h150: m_int  = d[27:16];
      12'h154: m_spr  = d[7:0];
      default: ;
    endcase
  endtask

  task automatic chk(input string tag, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  function automatic string tag_of(input logic [11:0] a);
    case (a)
      12'h140: return "R2";
      12'h144: return "R4";
      12'h14C: return "R5";
      12'h150, 12'h154: return "R6";
      12'h15C: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic check_all(input string tag);
    chk(tag, "pll_run", 32'(pll_run), 32'(m_run));
    chk("R3", "ssc_en", 32'(ssc_en), 32'(m_ssc));
    chk("R3", "down_spread", 32'(down_spread), 32'(m_ds));
    chk("R4", "post_div1", 32'(post_div1), 32'(m_pd1));
    chk("R4", "post_div2", 32'(post_div2), 32'(m_pd2));
    chk("R4", "ref_div", 32'(ref_div), 32'(m_ref));
    chk("R5", "frac", 32'(frac), 32'(m_frac));
    chk("R6", "int_mult", 32'(int_mult), 32'(m_int));
    chk("R6", "spread_val", 32'(spread_val), 32'(m_spr));
    for (int i = 0; i < 10; i++) begin
      addr = addrs[i];
      #0.1;
      chk(tag_of(addrs[i]), "R8 readback", rdata, exp_read(addrs[i]));
    end
  endtask

  // Drive at negedge; R11: same-cycle read sees the old value.
  task automatic bus_write(input logic [11:0] a, input logic [31:0] d, input logic we);
    @(negedge clk);
    addr = a; wdata = d; wr_en = we;
    #0.1;
    if (we) chk("R11", "read during write", rdata, exp_read(a));
    @(posedge clk);
    #0.5;
    if (we) model_write(a, d);
    else    tests = tests;  // R10: model unchanged when strobe is low
    wr_en = 1'b0;
    @(negedge clk);
    check_all(we ? tag_of(a) : "R10");
  endtask

  initial begin
    m_run = 0; m_ssc = 0; m_ds = 0; m_pd1 = 0; m_pd2 = 0; m_ref = 0;
    m_frac = 0; m_int = 0; m_spr = 0;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");
    // R2: data without enable must not release standby
    bus_write(12'h140, 32'h0000_FFFF, 1'b1);
    chk("R2", "run without enable", 32'(pll_run), 32'd0);
    bus_write(12'h140, 32'h0001_0001, 1'b1);
    chk("R2", "run with enable", 32'(pll_run), 32'd1);
    // R3: only down-spread enable
    bus_write(12'h140, 32'h0010_0014, 1'b1);
    chk("R3", "ssc kept", 32'(ssc_en), 32'd0);
    chk("R3", "ds set", 32'(down_spread), 32'd1);
    // R4: only ref divider enable
    bus_write(12'h144, 32'h0100_3F77, 1'b1);
    chk("R4", "ref loaded", 32'(ref_div), 32'h3F);
    chk("R4", "pd1 kept", 32'(post_div1), 32'd0);
    // R8: enables read back as 0
    addr = 12'h144; #0.1;
    chk("R8", "enable bits", rdata & 32'hFFFF_0000, 32'd0);
    // R10: strobe low
    bus_write(12'h14C, 32'hABCD_EF12, 1'b0);
    chk("R10", "frac idle", 32'(frac), 32'd0);
    // R7: write to monitor, lock toggling
    lock_in = 1'b1;
    bus_write(12'h15C, 32'hFFFF_FFFF, 1'b1);
    addr = 12'h15C; #0.1;
    chk("R7", "monitor lock", rdata, 32'h10);
    // R9: unmapped write
    bus_write(12'h158, 32'hFFFF_FFFF, 1'b1);
    for (int n = 0; n < 400; n++) begin
      logic [11:0] a;
      logic [31:0] d;
      a = addrs[$urandom_range(0, 9)];
      d = $urandom;
      lock_in = 1'($urandom);
      bus_write(a, d, ($urandom_range(0, 4) != 0));
    end
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule